// File: doc/BRIEF.md
# Single-Sector Programmed-I/O Disk Command Engine

This block is a host-side engine that moves one 512-byte sector to or from an IDE-style disk, using only programmed register accesses on a simple synchronous I/O port. A client hands it a 28-bit logical block address, a drive select bit and a direction. The engine then runs the whole exchange by itself. It polls the status register until the drive can take a command. It writes the parameter registers in a fixed order and issues the command byte. For a write, it streams the sector out through the data port. For a read, it waits for the drive's completion interrupt, polls again, and drains the sector. It ends by reporting completion or a fault.

Sector words pass through ready/valid word ports. A slow source or sink stalls the bus accesses and no words are lost. When the drive signals a fault in either status poll, the engine reads the error register once and hands the fault byte back together with the completion pulse.

Top module: `pio_sector_engine`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `bus_rd`, `bus_wr`, `done`, `err` and `rd_valid` are 0.
- R2: In the cycle after a request is accepted, the engine reads address 0x1F7 on every cycle until a returned status has bit 7 (busy) clear and bit 6 (ready) set. No bus write occurs before that.
- R3: The parameter script consists of bus writes on consecutive cycles, in this order: 0x00 to 0x3F6, 0x01 to 0x1F2, then LBA bits 7:0 to 0x1F3, bits 15:8 to 0x1F4 and bits 23:16 to 0x1F5. Each byte sits in the low 8 bits of `bus_wdata` with the upper bits zero.
- R4: The next script write puts 0xE0 OR (drive bit << 4) OR LBA bits 27:24 into 0x1F6.
- R5: The last script write puts the command byte into 0x1F7. The byte is 0x30 for a write request and 0x20 for a read request.
- R6: For a write, each word accepted on the `wr_*` port (valid and ready high together) produces exactly one bus write of that word to 0x1F0 on the following cycle, in order. There are 128 words, and no bus write occurs on a cycle after which no word was accepted.
- R7: For a read, 0x1F0 is not accessed before `irq` is seen. After `irq`, the engine polls status as in R2 and then performs 128 single-cycle reads of 0x1F0. Each word is presented on `rd_data`/`rd_valid` and held until `rd_ready`. The next bus read issues only after the previous word has been taken.
- R8: If a status sample in either poll has bit 7 clear and bit 0 (error) set, the engine performs one read of 0x1F1. It then pulses `done` with `err` high and `err_code` equal to that byte, and makes no further script or data access.
- R9: `done` is a one-cycle pulse, with `err` low on success. It follows the last write-stream word, or the handoff of the last read word. `req_ready` is low from acceptance until `done`, and requests offered meanwhile are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_lba | input | 28 | Logical block address |
| req_drive | input | 1 | Drive select bit |
| req_write | input | 1 | 1 = write sector, 0 = read sector |
| bus_addr | output | 16 | I/O port address |
| bus_wdata | output | 32 | I/O write data |
| bus_rdata | input | 32 | I/O read data, valid in the cycle `bus_rd` is high |
| bus_rd | output | 1 | I/O read strobe |
| bus_wr | output | 1 | I/O write strobe |
| irq | input | 1 | Drive completion interrupt |
| wr_data | input | 32 | Outgoing sector word |
| wr_valid | input | 1 | Outgoing word available |
| wr_ready | output | 1 | Engine takes an outgoing word |
| rd_data | output | 32 | Incoming sector word |
| rd_valid | output | 1 | Incoming word available |
| rd_ready | input | 1 | Sink takes the incoming word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Fault flag, qualified by `done` |
| err_code | output | 8 | Error register byte from the last fault |

## Verification
The bench feeds the engine status values that are busy-with-ready, not-ready, and finally ready. An engine that decodes the wrong bits would start the script early and write while the drive is still busy. The script is compared write by write against a reference queue, so a swapped LBA byte or a wrong drive/head nibble shows up at once. Source and sink are gapped on purpose. An engine that does not stall would drop, repeat or reorder words, or would read 0x1F0 more than 128 times. Faults are injected in both the pre-command poll and the post-interrupt poll, including one where the ready bit is also set. An engine that gives ready priority would drain data instead of reporting the error byte.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 16;
  localparam int LBA_W  = 28;

  localparam logic [ADDR_W-1:0] PORT_DATA   = 16'h01F0;
  localparam logic [ADDR_W-1:0] PORT_FAULT  = 16'h01F1;
  localparam logic [ADDR_W-1:0] PORT_COUNT  = 16'h01F2;
  localparam logic [ADDR_W-1:0] PORT_LBA0   = 16'h01F3;
  localparam logic [ADDR_W-1:0] PORT_LBA1   = 16'h01F4;
  localparam logic [ADDR_W-1:0] PORT_LBA2   = 16'h01F5;
  localparam logic [ADDR_W-1:0] PORT_DHEAD  = 16'h01F6;
  localparam logic [ADDR_W-1:0] PORT_CMDSTS = 16'h01F7;
  localparam logic [ADDR_W-1:0] PORT_CTRL   = 16'h03F6;

  localparam logic [7:0] OP_READ  = 8'h20;
  localparam logic [7:0] OP_WRITE = 8'h30;

  localparam int BIT_BUSY  = 7;
  localparam int BIT_READY = 6;
  localparam int BIT_FAULT = 0;

  localparam int SCRIPT_LEN = 7;

  typedef enum logic [3:0] {
    E_IDLE, E_POLL_CMD, E_SCRIPT, E_WSTREAM, E_WLAST,
    E_WAIT_IRQ, E_POLL_DATA, E_RDRAIN, E_FAULT_RD
  } eng_state_t;
endpackage

// File: rtl/pio_setup_script.sv
module pio_setup_script
  import pio_pkg::*;
(
  input  logic [2:0]       step,
  input  logic [LBA_W-1:0] lba,
  input  logic             drive,
  input  logic             write,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]       value
);
  always_comb begin
    case (step)
      3'd0: begin addr = PORT_CTRL;  value = 8'h00; end
      3'd1: begin addr = PORT_COUNT; value = 8'h01; end
      3'd2: begin addr = PORT_LBA0;  value = lba[7:0]; end
      3'd3: begin addr = PORT_LBA1;  value = lba[15:8]; end
      3'd4: begin addr = PORT_LBA2;  value = lba[23:16]; end
      3'd5: begin addr = PORT_DHEAD; value = 8'hE0 | {3'b000, drive, lba[27:24]}; end
      default: begin addr = PORT_CMDSTS; value = write ? OP_WRITE : OP_READ; end
    endcase
  end
endmodule

// File: rtl/pio_beat_counter.sv
module pio_beat_counter #(
  parameter int BEATS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);

  // R6 / R7: the beat after the final one starts a fresh sector
  a_r6_count_wraps: assert property (@(posedge clk) disable iff (rst)
    (inc && last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/pio_sector_engine.sv
module pio_sector_engine
  import pio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SECTOR_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LBA_W-1:0]  req_lba,
  input  logic              req_drive,
  input  logic              req_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              irq,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              done,
  output logic              err,
  output logic [7:0]        err_code
);
  localparam logic [2:0] STEP_END = 3'(SCRIPT_LEN);

  eng_state_t       state;
  logic [2:0]       step;
  logic [LBA_W-1:0] lba_q;
  logic             drive_q, write_q;
  logic [ADDR_W-1:0] scr_addr;
  logic [7:0]       scr_value;
  logic             beat_last, beat_inc, accept;
  logic             st_ready, st_fault;

  assign req_ready = (state == E_IDLE);
  assign wr_ready  = (state == E_WSTREAM);
  assign accept    = req_valid && req_ready;
  assign st_ready  = !bus_rdata[BIT_BUSY] && bus_rdata[BIT_READY];
  assign st_fault  = !bus_rdata[BIT_BUSY] && bus_rdata[BIT_FAULT];
  assign beat_inc  = (wr_ready && wr_valid) ||
                     (state == E_RDRAIN && rd_valid && rd_ready);

  pio_setup_script u_script (
    .step(step), .lba(lba_q), .drive(drive_q), .write(write_q),
    .addr(scr_addr), .value(scr_value)
  );

  pio_beat_counter #(.BEATS(SECTOR_WORDS)) u_beats (
    .clk(clk), .rst(rst), .clr(accept), .inc(beat_inc), .last(beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= E_IDLE;
      step     <= '0;
      lba_q    <= '0;
      drive_q  <= 1'b0;
      write_q  <= 1'b0;
      bus_addr <= '0;
      bus_wdata <= '0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      bus_wr <= 1'b0;
      case (state)
        E_IDLE: if (req_valid) begin
          lba_q    <= req_lba;
          drive_q  <= req_drive;
          write_q  <= req_write;
          step     <= '0;
          bus_rd   <= 1'b1;
          bus_addr <= PORT_CMDSTS;
          state    <= E_POLL_CMD;
        end
        E_POLL_CMD: begin
          if (st_fault) begin
            bus_addr <= PORT_FAULT;
            state    <= E_FAULT_RD;
          end else if (st_ready) begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b1;
            bus_addr  <= scr_addr;
            bus_wdata <= {{(DATA_W-8){1'b0}}, scr_value};
            step      <= step + 1'b1;
            state     <= E_SCRIPT;
          end
        end
        E_SCRIPT: begin
          if (step == STEP_END) begin
            state <= write_q ? E_WSTREAM : E_WAIT_IRQ;
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= scr_addr;
            bus_wdata <= {{(DATA_W-8){1'b0}}, scr_value};
            step      <= step + 1'b1;
          end
        end
        E_WSTREAM: if (wr_valid) begin
          bus_wr    <= 1'b1;
          bus_addr  <= PORT_DATA;
          bus_wdata <= wr_data;
          if (beat_last) state <= E_WLAST;
        end
        E_WLAST: begin
          done  <= 1'b1;
          state <= E_IDLE;
        end
        E_WAIT_IRQ: if (irq) begin
          bus_rd   <= 1'b1;
          bus_addr <= PORT_CMDSTS;
          state    <= E_POLL_DATA;
        end
        E_POLL_DATA: begin
          if (st_fault) begin
            bus_addr <= PORT_FAULT;
            state    <= E_FAULT_RD;
          end else if (st_ready) begin
            bus_addr <= PORT_DATA;
            state    <= E_RDRAIN;
          end
        end
        E_RDRAIN: begin
          if (bus_rd) begin
            rd_data  <= bus_rdata;
            rd_valid <= 1'b1;
            bus_rd   <= 1'b0;
          end else if (rd_valid && rd_ready) begin
            rd_valid <= 1'b0;
            if (beat_last) begin
              done  <= 1'b1;
              state <= E_IDLE;
            end else begin
              bus_rd <= 1'b1;
            end
          end
        end
        E_FAULT_RD: begin
          bus_rd   <= 1'b0;
          err_code <= bus_rdata[7:0];
          done     <= 1'b1;
          err      <= 1'b1;
          state    <= E_IDLE;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  // R2: an accepted request starts status polling on the next cycle
  a_r2_accept_polls: assert property (@(posedge clk) disable iff (rst)
    accept |=> (bus_rd && bus_addr == PORT_CMDSTS));
  // R9: no second request is taken while one is running
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: the fault flag only accompanies completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R6: every data-port write stems from an accepted source word
  a_r6_write_from_handshake: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == PORT_DATA) |-> $past(wr_valid && wr_ready));
  // R7: an untaken read word stays put
  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R7: a new bus read never overlaps a pending word
  a_r7_no_read_over_word: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == PORT_DATA) |-> !rd_valid);
  // R3: one bus access per cycle
  a_r3_single_access: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
endmodule

// File: tb/test_pio_sector_engine.sv
module test_pio_sector_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_lba = '0;
  logic        req_drive = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rd, bus_wr;
  logic        irq = 1'b0;
  logic [31:0] wr_data;
  logic        wr_valid;
  logic        wr_ready;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_ready;
  logic        done, err;
  logic [7:0]  err_code;

  always #4 clk = ~clk;

  pio_sector_engine i_pio_sector_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lba(req_lba), .req_drive(req_drive), .req_write(req_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .irq(irq),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .err_code(err_code)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdword(input int i);
    return 32'hC0DE0000 ^ (i * 32'h00010101);
  endfunction
  function automatic logic [31:0] wrword(input int i);
    return 32'h5EED0000 + i * 7;
  endfunction

  // drive model
  logic [7:0] dev_status = 8'h80;
  logic [7:0] dev_fault  = 8'h00;
  int dev_idx = 0;
  int cyc = 0;
  bit src_en = 1'b0;
  bit snk_en = 1'b0;
  int wr_idx = 0;
  bit irq_given = 1'b0;

  always_comb begin
    case (bus_addr)
      16'h01F7: bus_rdata = {24'h0, dev_status};
      16'h01F1: bus_rdata = {24'h0, dev_fault};
      16'h01F0: bus_rdata = rdword(dev_idx);
      default:  bus_rdata = 32'h0;
    endcase
  end

  assign wr_valid = src_en && (cyc[1:0] != 2'd3);
  assign wr_data  = wrword(wr_idx);
  assign rd_ready = snk_en && (cyc[2:0] != 3'd5);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd && bus_addr == 16'h01F0) dev_idx <= dev_idx + 1;
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
  end

  // reference: expected bus writes, checked each clock
  logic [47:0] expq[$];
  int rd_seen = 0;
  int done_cnt = 0;
  bit last_err = 1'b0;
  logic [7:0] last_code = 8'h00;

  task automatic push_script(input logic [27:0] lba, input bit drv, input bit wr);
    expq.push_back({16'h03F6, 32'h00});
    expq.push_back({16'h01F2, 32'h01});
    expq.push_back({16'h01F3, 24'h0, lba[7:0]});
    expq.push_back({16'h01F4, 24'h0, lba[15:8]});
    expq.push_back({16'h01F5, 24'h0, lba[23:16]});
    expq.push_back({16'h01F6, 24'h0, 8'hE0 | {3'b0, drv, lba[27:24]}});
    expq.push_back({16'h01F7, 24'h0, wr ? 8'h30 : 8'h20});
    if (wr) for (int i = 0; i < 128; i++) expq.push_back({16'h01F0, wrword(wr_idx + i)});
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_wr) begin
        string tag;
        logic [47:0] e;
        tag = (bus_addr == 16'h01F6) ? "R4" : (bus_addr == 16'h01F7) ? "R5" :
              (bus_addr == 16'h01F0) ? "R6" : "R3";
        // R2: no write unless the drive reports ready and not busy
        check(dev_status[6] && !dev_status[7], "R2 write before ready", {56'h0, dev_status}, 64'h40);
        if (expq.size() == 0) check(1'b0, {tag, " unexpected write"}, {bus_addr, bus_wdata}, 64'h0);
        else begin
          e = expq.pop_front();
          check({bus_addr, bus_wdata} == e, tag, {bus_addr, bus_wdata}, e);
        end
      end
      if (bus_rd && bus_addr == 16'h01F0 && !irq_given)
        check(1'b0, "R7 data read before irq", 64'h1F0, 64'h0);
      if (rd_valid && rd_ready) begin
        check(rd_data == rdword(rd_seen), "R7 read word", rd_data, rdword(rd_seen));
        rd_seen++;
      end
      if (done) begin
        done_cnt++;
        last_err = err;
        last_code = err_code;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  task automatic issue(input logic [27:0] lba, input bit drv, input bit wr);
    @(posedge clk); #1;
    req_valid = 1'b1; req_lba = lba; req_drive = drv; req_write = wr;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int start, input string tag);
    int n = 0;
    while (done_cnt == start && n < 5000) begin @(negedge clk); n++; end
    check(done_cnt == start + 1, {tag, " done pulse"}, done_cnt, start + 1);
  endtask

  initial begin : stimulus
    int d0, base_idx, base_wr, base_rd;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(!bus_rd && !bus_wr, "R1 strobes", {bus_rd, bus_wr}, 0);
    check(!done && !err && !rd_valid, "R1 done/err/rd_valid", {done, err, rd_valid}, 0);

    // write with busy, busy+ready, not-ready phases (R2..R6, R9)
    src_en = 1'b1;
    d0 = done_cnt;
    push_script(28'h5A1B2C3, 1'b1, 1'b1);
    issue(28'h5A1B2C3, 1'b1, 1'b1);
    repeat (4) @(posedge clk); #1 dev_status = 8'hC0;
    repeat (3) @(posedge clk); #1 dev_status = 8'h00;
    repeat (3) @(posedge clk); #1 dev_status = 8'h50;
    repeat (30) @(posedge clk); #1 req_valid = 1'b1; req_lba = 28'h0000777; req_write = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R9 busy refuses request", req_ready, 0);
    repeat (4) @(posedge clk); #1 req_valid = 1'b0;
    wait_done(d0, "R9 write");
    check(last_err == 1'b0, "R9 write err flag", last_err, 0);
    check(expq.size() == 0, "R6 all writes issued", expq.size(), 0);
    check(wr_idx == 128, "R6 words consumed", wr_idx, 128);
    @(negedge clk);
    check(!done, "R9 done one cycle", done, 0);
    src_en = 1'b0;

    // read (R4 nibble F, drive 0; R5 read code; R7)
    snk_en = 1'b1;
    d0 = done_cnt; base_idx = dev_idx; base_rd = rd_seen;
    push_script(28'hF123456, 1'b0, 1'b0);
    issue(28'hF123456, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R5 read script done", expq.size(), 0);
    check(done_cnt == d0, "R7 no completion before irq", done_cnt, d0);
    @(posedge clk); #1 dev_status = 8'h80; irq = 1'b1; irq_given = 1'b1;
    @(posedge clk); #1 irq = 1'b0;
    repeat (3) @(posedge clk); #1 dev_status = 8'h50;
    wait_done(d0, "R7 read");
    check(last_err == 1'b0, "R7 read err flag", last_err, 0);
    check(rd_seen - base_rd == 128, "R7 words delivered", rd_seen - base_rd, 128);
    check(dev_idx - base_idx == 128, "R7 data-port reads", dev_idx - base_idx, 128);
    irq_given = 1'b0;

    // fault after irq with ready also set (R8)
    d0 = done_cnt; base_idx = dev_idx; base_rd = rd_seen;
    push_script(28'h0000010, 1'b1, 1'b0);
    issue(28'h0000010, 1'b1, 1'b0);
    repeat (20) @(posedge clk);
    #1 dev_status = 8'h41; dev_fault = 8'h04; irq = 1'b1;
    @(posedge clk); #1 irq = 1'b0;
    wait_done(d0, "R8 read fault");
    check(last_err == 1'b1, "R8 read fault flag", last_err, 1);
    check(last_code == 8'h04, "R8 read fault code", last_code, 8'h04);
    check(dev_idx == base_idx && rd_seen == base_rd, "R8 no data moved", dev_idx - base_idx, 0);

    // fault before command (R8)
    src_en = 1'b1;
    d0 = done_cnt; base_wr = wr_idx;
    @(posedge clk); #1 dev_status = 8'h01; dev_fault = 8'h10;
    issue(28'h1234567, 1'b0, 1'b1);
    wait_done(d0, "R8 command fault");
    check(last_err == 1'b1, "R8 command fault flag", last_err, 1);
    check(last_code == 8'h10, "R8 command fault code", last_code, 8'h10);
    check(expq.size() == 0, "R8 no script writes", expq.size(), 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(wr_idx == base_wr, "R8 no words consumed", wr_idx - base_wr, 0);
    check(req_ready == 1'b1, "R9 idle after fault", req_ready, 1);
    finish_run();
  end
endmodule